// File: doc/BRIEF.md
# Hot-Plug Detect Controller

This block watches the hot-plug-detect line of a display connector and turns its level into a clean attached or removed indication for a host. The raw pin first passes through a two-stage synchronizer. A debouncer then accepts a new level only after that level has stayed steady for a programmable number of reference ticks. A divider that the host programs produces the ticks from the system clock.

The host talks to the block through a plain synchronous register port. It has a write strobe, a two-bit word address, write data and a combinational read-data bus. A single level interrupt goes back to the host. The interrupt watches one transition direction at a time, chosen by a select bit. After each event, software acknowledges it and normally flips the select bit so that it waits for the opposite transition. Turning the sensing enable off and then on again restarts detection. The pin is then judged afresh, and if its settled level matches the selected direction an event is raised even when nothing changed. No data stream crosses this block, so there is no valid/ready interface. Every pin is a plain control or status signal.

Top module: `hpd_ctrl`

## Requirements
- R1: After reset every register reads as zero, the cable flag is clear and `irq_o` is low.
- R2: Word 0 is the timer register. Bits [15:0] hold a divider count D and bit 16 is the timer enable. While the enable is set, a reference tick occurs once every D+1 clocks. While it is clear there are no ticks, so the debounced level cannot change.
- R3: Word 1 is the sense register. Bits [12:0] hold the timeout T and bit 16 is the sense enable. After the pin moves to a new steady level, at the positive clock edge numbered n from the change: the cable flag still shows the old level for n <= 2+T*(D+1), and it shows the new level for n >= 2+(T+1)*(D+1).
- R4: A pin pulse shorter than the debounce window leaves the cable flag unchanged, because any level change restarts the count.
- R5: While sense enable is clear, the cable flag reads 0 and no event is raised. Clearing the enable while a cable is present raises no removal event.
- R6: When sense enable goes from clear to set, the pin is judged afresh. Once it has been steady for the debounce window, the flag takes its level, and an event is raised if that level equals the selected direction, even when the level did not change.
- R7: Word 2 is the interrupt control register. Bit 0 is the interrupt enable, bit 1 is the attach select (1 = event on attach, 0 = event on removal) and bit 2 is the acknowledge. Only a settled transition in the selected direction sets the pending flag.
- R8: The pending flag is set only while the interrupt enable is set, and `irq_o` is high exactly when pending and the interrupt enable are both set.
- R9: Writing word 2 with bit 2 set clears pending, unless an event qualifies in the same cycle. Bit 2 always reads back as 0.
- R10: Word 3 is a read-only status register: bit 0 is pending and bit 1 is the cable flag. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hpd_pin_i | input | 1 | Raw hot-plug-detect pin, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The debounce latency is swept over every combination of timeout 0 to 3 and divider 0 to 2. Each combination is tried with a rising and a falling pin step, and the flag is sampled on every edge. This separates an off-by-one in the tick period from an off-by-one in the timeout count. Short pulses and a longer pulse, both at a fixed timeout, show the difference between a glitch that restarts the count and a level that is accepted. Steps in the selected and in the opposite direction, with the interrupt enable both on and off, separate direction qualification from enable gating. Enable toggles with the pin held high and held low show that a re-sense raises an event without any pin change.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  typedef enum logic [1:0] {
    ADDR_TIMER = 2'd0,
    ADDR_SENSE = 2'd1,
    ADDR_IRQ   = 2'd2,
    ADDR_STAT  = 2'd3
  } hpd_addr_e;

  localparam int TIMER_EN_BIT = 16;
  localparam int SENSE_EN_BIT = 16;
  localparam int IRQ_EN_BIT   = 0;
  localparam int IRQ_SEL_BIT  = 1;
  localparam int IRQ_ACK_BIT  = 2;
  localparam int ST_PEND_BIT  = 0;
  localparam int ST_CABLE_BIT = 1;
endpackage

// File: rtl/hpd_tick_gen.sv
module hpd_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce #(
  parameter int TMO_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             level_o,
  output logic             settle_o,
  output logic             settle_lvl_o
);
  logic             meta_q, sync_q;
  logic             en_d_q, fresh_q, lvl_q;
  logic [TMO_W-1:0] cnt_q;
  logic             hold;

  // restart when the synchronized level is about to move, or when nothing differs
  assign hold         = (meta_q != sync_q) || (!fresh_q && (sync_q == lvl_q));
  assign settle_o     = en_i && !hold && tick_i && (cnt_q >= tmo_i);
  assign settle_lvl_o = sync_q;
  assign level_o      = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q  <= 1'b0;
      fresh_q <= 1'b0;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      en_d_q <= en_i;
      if (!en_i) begin
        fresh_q <= 1'b0;
        lvl_q   <= 1'b0;
        cnt_q   <= '0;
      end else begin
        if (!en_d_q) fresh_q <= 1'b1;
        if (hold) begin
          cnt_q <= '0;
        end else if (tick_i) begin
          if (cnt_q >= tmo_i) begin
            lvl_q   <= sync_q;
            fresh_q <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wen_i,
  input  logic wsel_i,
  input  logic wack_i,
  input  logic settle_i,
  input  logic settle_lvl_i,
  output logic irq_en_o,
  output logic sel_o,
  output logic pend_o,
  output logic irq_o
);
  logic qual;

  assign qual  = settle_i && (settle_lvl_i == sel_o) && irq_en_o;
  assign irq_o = pend_o && irq_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o <= 1'b0;
      sel_o    <= 1'b0;
      pend_o   <= 1'b0;
    end else begin
      if (wr_i) begin
        irq_en_o <= wen_i;
        sel_o    <= wsel_i;
      end
      if (qual)                 pend_o <= 1'b1;
      else if (wr_i && wack_i)  pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hpd_ctrl.sv
module hpd_ctrl
  import hpd_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int TMO_W = 13
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hpd_pin_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  logic [DIV_W-1:0] tmr_div;
  logic             tmr_en;
  logic [TMO_W-1:0] sns_tmo;
  logic             sns_en;
  logic             tick, cable, settle, settle_lvl;
  logic             irq_en, irq_sel, pend;
  logic             wr_tmr, wr_sns, ack_wr;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign wr_tmr = reg_wr_i && (reg_addr_i == ADDR_TIMER);
  assign wr_sns = reg_wr_i && (reg_addr_i == ADDR_SENSE);
  assign ack_wr = reg_wr_i && (reg_addr_i == ADDR_IRQ) && reg_wdata_i[IRQ_ACK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_div <= '0;
      tmr_en  <= 1'b0;
      sns_tmo <= '0;
      sns_en  <= 1'b0;
    end else begin
      if (wr_tmr) begin
        tmr_div <= reg_wdata_i[DIV_W-1:0];
        tmr_en  <= reg_wdata_i[TIMER_EN_BIT];
      end
      if (wr_sns) begin
        sns_tmo <= reg_wdata_i[TMO_W-1:0];
        sns_en  <= reg_wdata_i[SENSE_EN_BIT];
      end
    end
  end

  hpd_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tmr_en),
    .div_i (tmr_div),
    .tick_o(tick)
  );

  hpd_debounce #(.TMO_W(TMO_W)) u_deb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (hpd_pin_i),
    .en_i        (sns_en),
    .tick_i      (tick),
    .tmo_i       (sns_tmo),
    .level_o     (cable),
    .settle_o    (settle),
    .settle_lvl_o(settle_lvl)
  );

  hpd_irq_ctrl u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i && (reg_addr_i == ADDR_IRQ)),
    .wen_i       (reg_wdata_i[IRQ_EN_BIT]),
    .wsel_i      (reg_wdata_i[IRQ_SEL_BIT]),
    .wack_i      (reg_wdata_i[IRQ_ACK_BIT]),
    .settle_i    (settle),
    .settle_lvl_i(settle_lvl),
    .irq_en_o    (irq_en),
    .sel_o       (irq_sel),
    .pend_o      (pend),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_TIMER: begin
        reg_rdata_o[DIV_W-1:0]    = tmr_div;
        reg_rdata_o[TIMER_EN_BIT] = tmr_en;
      end
      ADDR_SENSE: begin
        reg_rdata_o[TMO_W-1:0]    = sns_tmo;
        reg_rdata_o[SENSE_EN_BIT] = sns_en;
      end
      ADDR_IRQ: begin
        reg_rdata_o[IRQ_EN_BIT]  = irq_en;
        reg_rdata_o[IRQ_SEL_BIT] = irq_sel;
      end
      default: begin
        reg_rdata_o[ST_PEND_BIT]  = pend;
        reg_rdata_o[ST_CABLE_BIT] = cable;
      end
    endcase
  end
endmodule

// File: rtl/hpd_ctrl_chk.sv
module hpd_ctrl_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic [DIV_W-1:0] tmr_div,
  input logic             sns_en,
  input logic             cable,
  input logic             settle,
  input logic             pend,
  input logic             irq_en,
  input logic             ack_wr
);
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (tmr_div != '0)) |=> !tick); // R2

  AST_CABLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cable) && sns_en) |-> $past(tick)); // R3

  AST_OFF_NO_CABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sns_en |=> (!cable || sns_en)); // R5

  AST_PEND_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend) |-> $past(irq_en)); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !settle) |=> !pend); // R9
endmodule

bind hpd_ctrl hpd_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick),
  .tmr_div(tmr_div),
  .sns_en (sns_en),
  .cable  (cable),
  .settle (settle),
  .pend   (pend),
  .irq_en (irq_en),
  .ack_wr (ack_wr)
);

// File: tb/hpd_ctrl_tb.sv
`timescale 1ns/1ps
module hpd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  hpd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hpd_pin_i(pin), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 2'd3; wdata = '0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 2'd3;
  endtask

  task automatic waitc(input int c);
    repeat (c) @(negedge clk);
  endtask

  function automatic logic [31:0] tmr_w(input int d, input bit en);
    return {15'd0, en, 16'(d)};
  endfunction
  function automatic logic [31:0] sns_w(input int t, input bit en);
    return {15'd0, en, 3'd0, 13'(t)};
  endfunction
  function automatic logic [31:0] irq_w(input bit en, input bit sel, input bit ack);
    return {29'd0, ack, sel, en};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    waitc(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), r);
      chk(r == 0, "R1 reset readback", r, 0);
    end
    chk(irq == 1'b0, "R1 irq low", irq, 0);

    // R3 latency sweep, also exercises R2 tick period
    for (int t = 0; t < 4; t++) begin
      for (int d = 0; d < 3; d++) begin
        wreg(2'd0, tmr_w(d, 1));
        wreg(2'd1, sns_w(t, 1));
        waitc((t + 2) * (d + 1) + 8);
        for (int dir = 1; dir >= 0; dir--) begin
          int lo, hi;
          lo = 2 + t * (d + 1);
          hi = 2 + (t + 1) * (d + 1);
          @(negedge clk);
          pin = dir[0];
          for (int n = 1; n <= hi + 1; n++) begin
            @(posedge clk);
            #1;
            if (n <= lo) chk(rdata[1] == ~dir[0], "R3 flag too early", rdata[1], ~dir[0]);
            else if (n >= hi) chk(rdata[1] == dir[0], "R3 flag late", rdata[1], dir[0]);
          end
          waitc(4);
        end
      end
    end

    // R2 no ticks while timer disabled
    wreg(2'd0, tmr_w(0, 0));
    wreg(2'd1, sns_w(0, 1));
    pin = 1'b1;
    waitc(40);
    rreg(2'd3, r);
    chk(r[1] == 1'b0, "R2 no tick timer off", r[1], 0);
    wreg(2'd0, tmr_w(0, 1));
    waitc(8);
    rreg(2'd3, r);
    chk(r[1] == 1'b1, "R2 ticks resume", r[1], 1);
    rreg(2'd0, r);
    chk(r == 32'h0001_0000, "R2 timer readback", r, 32'h0001_0000);

    // R4 glitch rejection, T=3 D=0
    pin = 1'b0;
    wreg(2'd1, sns_w(3, 1));
    waitc(12);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); pin = 1'b1;
      waitc(k);
      pin = 1'b0;
      waitc(10);
      rreg(2'd3, r);
      chk(r[1] == 1'b0, "R4 short pulse ignored", r[1], 0);
    end
    @(negedge clk); pin = 1'b1;
    waitc(8);
    pin = 1'b0;
    rreg(2'd3, r);
    chk(r[1] == 1'b1, "R4 long pulse accepted", r[1], 1);
    waitc(12);

    // R7 / R8 direction and enable qualification
    wreg(2'd1, sns_w(1, 1));
    wreg(2'd2, irq_w(1, 1, 0));
    rreg(2'd2, r);
    chk(r == 32'h3, "R7 irq ctrl readback", r, 3);
    pin = 1'b1; waitc(12);
    pin = 1'b0; waitc(12);
    rreg(2'd3, r);
    chk(r[0] == 1'b1, "R7 attach raises pending", r[0], 1);
    chk(irq == 1'b1, "R8 irq high", irq, 1);
    // R9 acknowledge with enable cleared
    wreg(2'd2, irq_w(0, 0, 1));
    rreg(2'd3, r);
    chk(r[0] == 1'b0, "R9 ack clears pending", r[0], 0);
    chk(irq == 1'b0, "R9 irq low after ack", irq, 0);
    rreg(2'd2, r);
    chk(r == 0, "R9 ack bit reads zero", r, 0);
    // attach-select, enable on, removal only: no pending
    wreg(2'd2, irq_w(1, 1, 0));
    pin = 1'b1; waitc(12);
    wreg(2'd2, irq_w(1, 1, 1));
    pin = 1'b0; waitc(12);
    rreg(2'd3, r);
    chk(r[0] == 1'b0, "R7 removal ignored with attach select", r[0], 0);
    // enable off: transition does not set pending
    wreg(2'd2, irq_w(0, 1, 0));
    pin = 1'b1; waitc(12);
    rreg(2'd3, r);
    chk(r == 32'h2, "R8 no pending while disabled", r, 2);
    chk(irq == 1'b0, "R8 irq low while disabled", irq, 0);
    // removal select
    wreg(2'd2, irq_w(1, 0, 0));
    pin = 1'b0; waitc(12);
    rreg(2'd3, r);
    chk(r == 32'h1, "R7 removal raises pending", r, 1);
    // R10 status is read-only
    wreg(2'd3, 32'hFFFF_FFFF);
    rreg(2'd3, r);
    chk(r == 32'h1, "R10 status write ignored", r, 1);
    wreg(2'd2, irq_w(0, 0, 1));

    // R5 disable with cable present
    pin = 1'b1; waitc(12);
    wreg(2'd2, irq_w(1, 0, 0));
    wreg(2'd1, sns_w(1, 0));
    waitc(6);
    rreg(2'd3, r);
    chk(r == 0, "R5 disabled: no cable, no event", r, 0);
    chk(irq == 1'b0, "R5 irq low", irq, 0);

    // R6 re-sense with pin high, attach select
    wreg(2'd2, irq_w(1, 1, 0));
    wreg(2'd1, sns_w(1, 1));
    waitc(12);
    rreg(2'd3, r);
    chk(r == 32'h3, "R6 re-sense attach event", r, 3);
    wreg(2'd2, irq_w(0, 0, 1));
    // R6 re-sense with pin low, removal select, no level change
    pin = 1'b0; waitc(12);
    wreg(2'd2, irq_w(1, 0, 1));
    rreg(2'd3, r);
    chk(r == 0, "R6 idle before toggle", r, 0);
    wreg(2'd1, sns_w(1, 0));
    wreg(2'd1, sns_w(1, 1));
    waitc(12);
    rreg(2'd3, r);
    chk(r == 32'h1, "R6 re-sense removal event", r, 1);
    chk(irq == 1'b1, "R6 irq on re-sense", irq, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule